// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

A memory-mapped watchdog that counts down on a periodic tick input and escalates in two steps. When the count runs out the first time, it latches a timeout flag, can fire a one-cycle SMI pulse, reloads itself and arms a second stage. If software still has not kicked it when the count runs out again, it latches a second-timeout flag and raises a system reset request. Setting the no-reboot bit suppresses that request. An external strap can force the no-reboot bit on, so software must read the bit back after clearing it.

Software uses a small register bus: address, write data and write strobe in, combinational read data out. Writing the kick register with any nonzero value in its low five bits reloads the count from the timer-value register. A new timer value is stored at once but only reaches the count at the next kick or reload. The status flags are write-one-to-clear. The second-timeout flag and the boot flag sit in a power-on reset domain, so after a watchdog reset they still show why the system restarted.

Register map, with word addresses: 0 kick, 1 timer value, 2 current count (read only), 3 status A (bit 0 timeout), 4 status B (bit 1 second timeout, bit 2 boot), 5 control (bit 11 halt, bit 9 expiry-seen), 6 config (bit 0 SMI enable, bit 1 no-reboot).

Top module: `wdt_two_stage`

## Requirements
- R1: Status flags are set only by hardware. Writing 1 to a flag's bit clears it. Writing 0 leaves it unchanged.
- R2: A status B write with bit 1 set clears only the second-timeout flag. The boot flag (bit 2) clears only on a status B write that has bit 2 set and bit 1 clear.
- R3: A write to the kick address reloads the count from the timer value only when wdata[4:0] is nonzero. Any other kick write changes nothing.
- R4: A timer-value write does not alter the running count. The new value takes effect at the next reload.
- R5: While control bit 11 (halt) is 1 the count holds. While it is 0 the count drops by one per tick. After reset the halt bit is 1.
- R6: Control bit 9 is set at the first-stage expiry and changes on no control write. All control bits other than 9 and 11 read 0.
- R7: Config bit 1 (no-reboot) is 1 after reset and blocks the reset request. A software write can clear it unless lock_strap_i is high, in which case it reads back 1.
- R8: At the first-stage expiry, smi_o pulses for one cycle only if config bit 0 is 1.
- R9: A timer-value write below 2 stores 2. A write above 2^TW-1 stores 2^TW-1.
- R10: A tick that finds the count at 1 is an expiry. The count reloads from the timer value. The first expiry since the last kick sets status A bit 0 and arms the second stage.
- R11: An expiry while the second stage is armed sets status B bit 1. It also latches rst_req_o high until reset, unless no-reboot is set. A kick disarms the second stage.
- R12: The second-timeout and boot flags keep their values through rst_n and are cleared or set only by por_n. Power-on sets the boot flag and clears the second-timeout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the timer domain |
| por_n | input | 1 | Synchronous active-low power-on reset, also resets the timer domain |
| tick_i | input | 1 | Count-down tick, one cycle per tick |
| lock_strap_i | input | 1 | Forces the no-reboot bit to 1 |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for addr_i |
| smi_o | output | 1 | One-cycle SMI pulse at the first-stage expiry |
| rst_req_o | output | 1 | System reset request, held until reset |

## Verification
The assertions assume that at most one register write occurs per cycle and that a kick and a timer-value write never land in the same cycle. The single shared address bus enforces this. They also assume the tick is a synchronous one-cycle strobe. The bench drives every write and every tick from tasks at the falling edge, one operation at a time, and keeps random tick counts below the programmed value whenever the count is checked directly. Expiries are produced only in directed sequences whose outcome is worked out in advance.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [2:0] {
        A_KICK = 3'd0,
        A_TMR  = 3'd1,
        A_CNT  = 3'd2,
        A_STSA = 3'd3,
        A_STSB = 3'd4,
        A_CTRL = 3'd5,
        A_CFG  = 3'd6
    } wdt_addr_e;

    localparam int KICK_MASK_W = 5;
    localparam int TO_BIT      = 0;
    localparam int SEC_BIT     = 1;
    localparam int BOOT_BIT    = 2;
    localparam int SEEN_BIT    = 9;
    localparam int HALT_BIT    = 11;
    localparam int SMIEN_BIT   = 0;
    localparam int NORB_BIT    = 1;
    localparam int MIN_TICKS   = 2;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int TW   = 10,
    parameter int INIT = 4
) (
    input  logic          clk,
    input  logic          rst_ok,
    input  logic          kick_i,
    input  logic          tick_i,
    input  logic          halt_i,
    input  logic [TW-1:0] tmr_i,
    output logic [TW-1:0] cnt_o,
    output logic          exp1_o,
    output logic          exp2_o
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          armed;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    expire;

    always_comb begin
        st_d   = st_q;
        expire = tick_i && !halt_i && !kick_i && (st_q.cnt <= TW'(1));
        if (kick_i) begin
            st_d.cnt   = tmr_i;
            st_d.armed = 1'b0;
        end else if (tick_i && !halt_i) begin
            if (st_q.cnt <= TW'(1)) begin
                st_d.cnt   = tmr_i;
                st_d.armed = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_ok) begin
            st_q.cnt   <= TW'(INIT);
            st_q.armed <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.cnt;
    assign exp1_o = expire && !st_q.armed;
    assign exp2_o = expire && st_q.armed;
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic clk,
    input  logic rst_ok,
    input  logic por_n,
    input  logic exp1_i,
    input  logic exp2_i,
    input  logic smi_en_i,
    input  logic noreboot_i,
    input  logic clr_to_i,
    input  logic stsb_we_i,
    input  logic wsec_i,
    input  logic wboot_i,
    output logic to_o,
    output logic seen_o,
    output logic sec_o,
    output logic boot_o,
    output logic smi_o,
    output logic rst_req_o
);
    typedef struct packed {
        logic to;
        logic seen;
        logic smi;
        logic rreq;
    } main_st_t;

    typedef struct packed {
        logic sec;
        logic boot;
    } por_st_t;

    main_st_t m_d, m_q;
    por_st_t  p_d, p_q;

    always_comb begin
        m_d      = m_q;
        p_d      = p_q;
        m_d.smi  = exp1_i && smi_en_i;
        m_d.seen = m_q.seen || exp1_i;
        m_d.rreq = m_q.rreq || (exp2_i && !noreboot_i);
        if (exp1_i)        m_d.to = 1'b1;
        else if (clr_to_i) m_d.to = 1'b0;
        if (exp2_i)                  p_d.sec = 1'b1;
        else if (stsb_we_i && wsec_i) p_d.sec = 1'b0;
        if (stsb_we_i && wboot_i && !wsec_i) p_d.boot = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_ok) m_q <= '0;
        else         m_q <= m_d;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            p_q.sec  <= 1'b0;
            p_q.boot <= 1'b1;
        end else begin
            p_q <= p_d;
        end
    end

    assign to_o      = m_q.to;
    assign seen_o    = m_q.seen;
    assign smi_o     = m_q.smi;
    assign rst_req_o = m_q.rreq;
    assign sec_o     = p_q.sec;
    assign boot_o    = p_q.boot;
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
#(
    parameter int TW   = 10,
    parameter int DW   = 16,
    parameter int INIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por_n,
    input  logic          tick_i,
    input  logic          lock_strap_i,
    input  logic          we_i,
    input  logic [2:0]    addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          smi_o,
    output logic          rst_req_o
);
    localparam logic [DW-1:0] MAXV = DW'((1 << TW) - 1);
    localparam logic [DW-1:0] MINV = DW'(MIN_TICKS);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          halt;
        logic          smi_en;
        logic          noreboot;
    } reg_st_t;

    reg_st_t r_d, r_q;
    logic    rst_ok;
    logic    kick, exp1, exp2, exp1_raw, exp2_raw;
    logic    to_f, seen_f, sec_f, boot_f;
    logic [TW-1:0] cnt;

    assign rst_ok = rst_n && por_n;
    assign kick   = we_i && (addr_i == A_KICK) && (|wdata_i[KICK_MASK_W-1:0]);
    assign exp1   = exp1_raw && rst_ok;
    assign exp2   = exp2_raw && rst_ok;

    always_comb begin
        r_d = r_q;
        if (we_i) begin
            unique case (addr_i)
                A_TMR: begin
                    if (wdata_i < MINV)      r_d.tmr = TW'(MINV);
                    else if (wdata_i > MAXV) r_d.tmr = TW'(MAXV);
                    else                     r_d.tmr = wdata_i[TW-1:0];
                end
                A_CTRL: r_d.halt = wdata_i[HALT_BIT];
                A_CFG: begin
                    r_d.smi_en   = wdata_i[SMIEN_BIT];
                    r_d.noreboot = wdata_i[NORB_BIT] || lock_strap_i;
                end
                default: ;
            endcase
        end
        if (lock_strap_i) r_d.noreboot = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_ok) begin
            r_q.tmr      <= TW'(INIT);
            r_q.halt     <= 1'b1;
            r_q.smi_en   <= 1'b0;
            r_q.noreboot <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    wdt_counter #(.TW(TW), .INIT(INIT)) i_counter (
        .clk    (clk),
        .rst_ok (rst_ok),
        .kick_i (kick),
        .tick_i (tick_i),
        .halt_i (r_q.halt),
        .tmr_i  (r_q.tmr),
        .cnt_o  (cnt),
        .exp1_o (exp1_raw),
        .exp2_o (exp2_raw)
    );

    wdt_status i_status (
        .clk        (clk),
        .rst_ok     (rst_ok),
        .por_n      (por_n),
        .exp1_i     (exp1),
        .exp2_i     (exp2),
        .smi_en_i   (r_q.smi_en),
        .noreboot_i (r_q.noreboot),
        .clr_to_i   (we_i && (addr_i == A_STSA) && wdata_i[TO_BIT]),
        .stsb_we_i  (we_i && (addr_i == A_STSB)),
        .wsec_i     (wdata_i[SEC_BIT]),
        .wboot_i    (wdata_i[BOOT_BIT]),
        .to_o       (to_f),
        .seen_o     (seen_f),
        .sec_o      (sec_f),
        .boot_o     (boot_f),
        .smi_o      (smi_o),
        .rst_req_o  (rst_req_o)
    );

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            A_TMR:  rdata_o = DW'(r_q.tmr);
            A_CNT:  rdata_o = DW'(cnt);
            A_STSA: rdata_o[TO_BIT] = to_f;
            A_STSB: begin
                rdata_o[SEC_BIT]  = sec_f;
                rdata_o[BOOT_BIT] = boot_f;
            end
            A_CTRL: begin
                rdata_o[SEEN_BIT] = seen_f;
                rdata_o[HALT_BIT] = r_q.halt;
            end
            A_CFG: begin
                rdata_o[SMIEN_BIT] = r_q.smi_en;
                rdata_o[NORB_BIT]  = r_q.noreboot;
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/wdt_two_stage_chk.sv
module wdt_two_stage_chk #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst_ok,
    input logic          kick,
    input logic          halt,
    input logic [TW-1:0] cnt,
    input logic [TW-1:0] tmr,
    input logic          smi,
    input logic          smi_en,
    input logic          rreq,
    input logic          noreboot
);
    p_kick_reload_r3: assert property (@(posedge clk) disable iff (!rst_ok)
        kick |=> (cnt == $past(tmr)));

    p_halt_hold_r5: assert property (@(posedge clk) disable iff (!rst_ok)
        (halt && !kick) |=> $stable(cnt));

    p_tmr_range_r9: assert property (@(posedge clk) disable iff (!rst_ok)
        tmr >= TW'(2));

    p_noreboot_block_r7: assert property (@(posedge clk) disable iff (!rst_ok)
        $rose(rreq) |-> !$past(noreboot));

    p_smi_gate_r8: assert property (@(posedge clk) disable iff (!rst_ok)
        smi |-> $past(smi_en));
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.TW(TW)) i_chk (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .kick     (kick),
    .halt     (r_q.halt),
    .cnt      (cnt),
    .tmr      (r_q.tmr),
    .smi      (smi_o),
    .smi_en   (r_q.smi_en),
    .rreq     (rst_req_o),
    .noreboot (r_q.noreboot)
);

// File: tb/test_wdt_two_stage.sv
`timescale 1ns/1ps
module test_wdt_two_stage;
    localparam int TW = 10;
    localparam int DW = 16;
    localparam int MAXT = (1 << TW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, por_n = 1'b0, tick = 1'b0, strap = 1'b0;
    logic we = 1'b0;
    logic [2:0] addr = '0;
    logic [DW-1:0] wdata = '0, rdata;
    logic smi, rreq;
    int runs = 0, fails = 0, smi_seen = 0;
    logic [DW-1:0] v;

    always #4 clk = ~clk;

    wdt_two_stage #(.TW(TW), .DW(DW), .INIT(4)) i_wdt_two_stage (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .tick_i(tick),
        .lock_strap_i(strap), .we_i(we), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .smi_o(smi), .rst_req_o(rreq));

    always @(negedge clk) if (smi) smi_seen++;

    function automatic int clampf(int x);
        if (x < 2) return 2;
        if (x > MAXT) return MAXT;
        return x;
    endfunction

    task automatic chk(string r, int act, int exp);
        runs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", r, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        we = 1'b1; addr = 3'(a); wdata = DW'(d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(int a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = 3'(a);
        #1 d = rdata;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    initial begin
        #1600000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        int s;
        s = $urandom(32'd77);
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        // reset state
        rd(5, v); chk("R5 halt after reset", v, 16'h0800);
        rd(4, v); chk("R12 boot set by por", v, 16'h0004);
        rd(6, v); chk("R7 noreboot after reset", v, 16'h0002);
        rd(2, v); chk("R5 count after reset", v, 4);
        // clamp
        wr(1, 0);     rd(1, v); chk("R9 clamp low", v, 2);
        wr(1, 5000);  rd(1, v); chk("R9 clamp high", v, MAXT);
        // R4/R3 while halted
        wr(1, 6);     rd(2, v); chk("R4 no effect before reload", v, 4);
        wr(0, 32'h20); rd(2, v); chk("R3 kick low bits zero ignored", v, 4);
        wr(0, 32'h01); rd(2, v); chk("R3 kick reloads", v, 6);
        ticks(3);     rd(2, v); chk("R5 halted count holds", v, 6);
        // random run with halt off
        wr(5, 0);
        for (int k = 0; k < 8; k++) begin
            int x, c, n;
            x = int'($urandom % 1500);
            c = clampf(x);
            wr(1, x); rd(1, v); chk("R9 random clamp", v, c);
            wr(0, 32'h1F);
            n = int'($urandom % ((c - 1 < 40) ? c - 1 : 40));
            ticks(n); rd(2, v); chk("R5 random countdown", v, c - n);
        end
        // first expiry with SMI
        wr(1, 3); wr(6, 3); wr(0, 1); smi_seen = 0;
        ticks(3);
        rd(3, v); chk("R10 timeout flag", v, 1);
        rd(2, v); chk("R10 reload after expiry", v, 3);
        chk("R8 smi pulse once", smi_seen, 1);
        rd(5, v); chk("R6 seen bit", v, 16'h0200);
        wr(5, 16'hFFFF); rd(5, v); chk("R6 ctrl write keeps bit 9", v, 16'h0A00);
        wr(5, 0);        rd(5, v); chk("R6 ctrl clear keeps bit 9", v, 16'h0200);
        wr(3, 0); rd(3, v); chk("R1 write zero no effect", v, 1);
        wr(3, 1); rd(3, v); chk("R1 write one clears", v, 0);
        // second expiry, noreboot set
        ticks(3);
        rd(4, v); chk("R11 second flag", v, 16'h0006);
        chk("R7 noreboot blocks request", rreq, 0);
        wr(4, 6); rd(4, v); chk("R2 combined write clears only second", v, 16'h0004);
        wr(4, 4); rd(4, v); chk("R2 boot cleared alone", v, 0);
        // no SMI when disabled, kick disarms
        wr(6, 0); rd(6, v); chk("R7 noreboot cleared", v, 0);
        wr(0, 1); smi_seen = 0;
        ticks(3); wr(0, 1); ticks(3);
        rd(4, v); chk("R11 kick disarms", v, 0);
        chk("R11 no request after kick", rreq, 0);
        chk("R8 smi gated off", smi_seen, 0);
        ticks(3);
        rd(4, v); chk("R11 second expiry flag", v, 16'h0002);
        chk("R11 reset request", rreq, 1);
        // timer reset keeps por domain
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk("R11 request cleared by reset", rreq, 0);
        rd(4, v); chk("R12 second flag survives rst_n", v, 16'h0002);
        @(negedge clk) por_n = 1'b0;
        @(negedge clk) por_n = 1'b1;
        rd(4, v); chk("R12 por sets boot clears second", v, 16'h0004);
        // strap lock
        strap = 1'b1;
        wr(6, 0); rd(6, v); chk("R7 strap holds noreboot", v, 16'h0002);
        strap = 1'b0;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule